// File: doc/BRIEF.md
# Page-Chunked Single-Channel DMA Engine

This block moves a block of words between one peripheral and memory while the processor does other work. Software loads a starting physical word address, a word count, a peripheral identifier and a direction through a four-entry register port, then sets a go bit. From then on the engine works as a bus master. It asks an external arbiter for the bus and generates every memory address itself. It also paces the peripheral through a request/acknowledge handshake.

Physical addresses may not wrap into an unrelated page. The engine therefore cuts the transfer into chunks. Each chunk lies inside one page of `PAGE_WORDS` words. Between chunks the bus is handed back for at least one cycle and then requested again. The processor hears from the engine only once, through a level interrupt. The interrupt is raised when the last word has moved, or when the peripheral reports a fault. After a fault, the count of words that were not moved can be read back.

Top module: `dma_pager`

## Requirements
- R1: After reset, `bus_req`, `irq`, `mem_en` and `dev_req` are low and the status register (offset 3) reads zero.
- R2: Register offsets are: 0 control, 1 start address, 2 word count, 3 status. The control word has bit 0 = go, bit 1 = direction (0 peripheral-to-memory, 1 memory-to-peripheral) and bits 8 and up = peripheral identifier. Reading offset 0 returns the latched direction and identifier in the same positions. Reading offset 1 returns the current address and reading offset 2 the remaining count.
- R3: Words move only while `bus_req` and `bus_gnt` are both high. The engine requests the bus before its first word.
- R4: In peripheral-to-memory mode, word i of a transfer is written to memory at start address + i, with the data the peripheral presented when it acknowledged.
- R5: In memory-to-peripheral mode, word i is read from start address + i and presented on `dev_wdata` in the cycle the peripheral acknowledges.
- R6: Each chunk has the length min(remaining, PAGE_WORDS − (address mod PAGE_WORDS)). No chunk spans two pages.
- R7: After each chunk `bus_req` goes low for at least one cycle before the next chunk is requested, so the grant rises once per chunk.
- R8: When the whole count has moved, the engine goes idle and sets done (status bit 1), and `irq` goes high. The remaining count then reads 0 and the address reads start + count.
- R9: Done and error (status bit 2) stay set until software writes 1 to that status bit, or until the next accepted go. `irq` is high exactly while either bit is set.
- R10: A control write with go set while busy (status bit 0) is ignored. It changes neither the latched direction and identifier nor the running transfer.
- R11: A go with a word count of zero sets done without ever raising `bus_req`.
- R12: When `dev_err` is high during a transfer cycle with the bus granted, no word moves in that cycle. The engine stops and sets error without setting done. The remaining count then reads the number of words not moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for read and write |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| irq | output | 1 | Completion or fault interrupt level |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| dev_id | output | ID_W | Identifier of the peripheral being served |
| dev_req | output | 1 | Engine ready for one word from or to the peripheral |
| dev_ack | input | 1 | Peripheral accepts or supplies a word this cycle |
| dev_err | input | 1 | Peripheral fault |
| dev_rdata | input | DATA_W | Word from the peripheral |
| dev_wdata | output | DATA_W | Word to the peripheral |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, same cycle |

## Verification
The assertions assume the following about the arbiter and the peripheral:
- The arbiter gives `bus_gnt` only while `bus_req` is high, and removes it within a cycle after the request falls.
- Memory returns read data in the same cycle.
- A peripheral fault stays asserted until the engine has stopped.

The bench's arbiter model follows these rules: it grants one cycle after a request and drops the grant with it. Its peripheral model acknowledges on alternate cycles and holds `dev_err` until the transfer ends. Software writes are never placed in the single cycle where a transfer finishes.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARB,
    ST_MOVE,
    ST_GAP
  } eng_state_t;

  localparam logic [1:0] CSR_CTRL = 2'd0;
  localparam logic [1:0] CSR_ADDR = 2'd1;
  localparam logic [1:0] CSR_LEN  = 2'd2;
  localparam logic [1:0] CSR_STAT = 2'd3;

  localparam int unsigned CTRL_GO_BIT  = 0;
  localparam int unsigned CTRL_DIR_BIT = 1;
  localparam int unsigned CTRL_ID_LSB  = 8;

  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_DONE_BIT = 1;
  localparam int unsigned STAT_ERR_BIT  = 2;

endpackage

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned PAGE_WORDS = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  remain,
  output logic [LEN_W-1:0]  chunk
);

  localparam int unsigned PG_B = $clog2(PAGE_WORDS);

  logic [PG_B-1:0]  offset;
  logic [LEN_W-1:0] room;
  logic             unused_hi;

  assign offset    = addr[PG_B-1:0];
  assign unused_hi = ^addr[ADDR_W-1:PG_B];

  // Words left before the next page boundary.
  assign room  = LEN_W'(PAGE_WORDS) - LEN_W'(offset);
  assign chunk = (remain < room) ? remain : room;

endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned ID_W       = 4,
  parameter int unsigned PAGE_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cfg_dir,
  input  logic [ID_W-1:0]   cfg_id,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [LEN_W-1:0]  chunk_len,
  input  logic              bus_gnt,
  input  logic              dev_ack,
  input  logic              dev_err,
  output logic              bus_req,
  output logic              dev_req,
  output logic              xfer_word,
  output logic              dir,
  output logic [ID_W-1:0]   dev_id,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  remain,
  output logic              busy,
  output logic              fin,
  output logic              fault
);

  localparam int unsigned PG_B = $clog2(PAGE_WORDS);
  localparam int unsigned PN_W = ADDR_W - PG_B;

  eng_state_t        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic [LEN_W-1:0]  chunk_q, chunk_d;
  logic [PN_W-1:0]   page_q, page_d;
  logic              dir_q, dir_d;
  logic [ID_W-1:0]   id_q, id_d;
  logic              fin_q, fin_d;
  logic              fault_q, fault_d;
  logic              cfg_en;

  assign bus_req   = (state_q == ST_ARB) || (state_q == ST_MOVE);
  assign dev_req   = (state_q == ST_MOVE) && bus_gnt;
  assign xfer_word = dev_req && dev_ack && !dev_err;
  assign cfg_en    = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    remain_d = remain_q;
    chunk_d  = chunk_q;
    page_d   = page_q;
    fin_d    = 1'b0;
    fault_d  = 1'b0;
    dir_d    = cfg_dir;
    id_d     = cfg_id;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          addr_d   = cfg_addr;
          remain_d = cfg_len;
          if (cfg_len == '0) fin_d = 1'b1;
          else               state_d = ST_ARB;
        end
      end
      ST_ARB: begin
        if (bus_gnt) begin
          chunk_d = chunk_len;
          page_d  = addr_q[ADDR_W-1:PG_B];
          state_d = ST_MOVE;
        end
      end
      ST_MOVE: begin
        if (bus_gnt) begin
          if (dev_err) begin
            fault_d = 1'b1;
            state_d = ST_IDLE;
          end else if (dev_ack) begin
            addr_d   = addr_q + 1'b1;
            remain_d = remain_q - 1'b1;
            chunk_d  = chunk_q - 1'b1;
            if (chunk_q == LEN_W'(1)) begin
              if (remain_q == LEN_W'(1)) begin
                fin_d   = 1'b1;
                state_d = ST_IDLE;
              end else begin
                state_d = ST_GAP;
              end
            end
          end
        end
      end
      ST_GAP:  state_d = ST_ARB;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      remain_q <= '0;
      chunk_q  <= '0;
      page_q   <= '0;
      dir_q    <= 1'b0;
      id_q     <= '0;
      fin_q    <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      addr_q   <= addr_d;
      remain_q <= remain_d;
      chunk_q  <= chunk_d;
      page_q   <= page_d;
      fin_q    <= fin_d;
      fault_q  <= fault_d;
      if (cfg_en) begin
        dir_q <= dir_d;
        id_q  <= id_d;
      end
    end
  end

  assign dir      = dir_q;
  assign dev_id   = id_q;
  assign cur_addr = addr_q;
  assign remain   = remain_q;
  assign busy     = (state_q != ST_IDLE);
  assign fin      = fin_q;
  assign fault    = fault_q;

  // R6
  page_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_word |-> (addr_q[ADDR_W-1:PG_B] == page_q));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_word |=> (remain_q == $past(remain_q) - 1'b1));

  // R7
  chunk_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_word && chunk_q == LEN_W'(1)) |=> !bus_req);

  // R11
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start && cfg_len == '0) |=> (!bus_req && fin_q));

  // R12
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MOVE && bus_gnt && dev_err) |=>
      (state_q == ST_IDLE && remain_q == $past(remain_q) && fault_q && !fin_q));

endmodule

// File: rtl/dma_csr.sv
module dma_csr
  import dma_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              fin,
  input  logic              fault,
  input  logic              dir,
  input  logic [ID_W-1:0]   dev_id,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  remain,
  output logic              start,
  output logic              cfg_dir,
  output logic [ID_W-1:0]   cfg_id,
  output logic [ADDR_W-1:0] cfg_addr,
  output logic [LEN_W-1:0]  cfg_len,
  output logic              irq
);

  logic [ADDR_W-1:0] addr_stage_q;
  logic [LEN_W-1:0]  len_stage_q;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              addr_en, len_en, clr_done, clr_err;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata;

  assign start    = reg_wr && (reg_addr == CSR_CTRL) && reg_wdata[CTRL_GO_BIT] && !busy;
  assign cfg_dir  = reg_wdata[CTRL_DIR_BIT];
  assign cfg_id   = reg_wdata[CTRL_ID_LSB +: ID_W];
  assign cfg_addr = addr_stage_q;
  assign cfg_len  = len_stage_q;

  assign addr_en  = reg_wr && (reg_addr == CSR_ADDR);
  assign len_en   = reg_wr && (reg_addr == CSR_LEN);
  assign clr_done = reg_wr && (reg_addr == CSR_STAT) && reg_wdata[STAT_DONE_BIT];
  assign clr_err  = reg_wr && (reg_addr == CSR_STAT) && reg_wdata[STAT_ERR_BIT];

  always_comb begin
    if (fin)                   done_d = 1'b1;
    else if (start || clr_done) done_d = 1'b0;
    else                       done_d = done_q;
    if (fault)                 err_d = 1'b1;
    else if (start || clr_err) err_d = 1'b0;
    else                       err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_stage_q <= '0;
      len_stage_q  <= '0;
      done_q       <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      if (addr_en) addr_stage_q <= reg_wdata[ADDR_W-1:0];
      if (len_en)  len_stage_q  <= reg_wdata[LEN_W-1:0];
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      CSR_CTRL: begin
        reg_rdata[CTRL_DIR_BIT]             = dir;
        reg_rdata[CTRL_ID_LSB +: ID_W]      = dev_id;
      end
      CSR_ADDR: reg_rdata = DATA_W'(cur_addr);
      CSR_LEN:  reg_rdata = DATA_W'(remain);
      default: begin
        reg_rdata[STAT_BUSY_BIT] = busy;
        reg_rdata[STAT_DONE_BIT] = done_q;
        reg_rdata[STAT_ERR_BIT]  = err_q;
      end
    endcase
  end

  assign irq = done_q || err_q;

  // R9
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_done && !fin) |=> !done_q);

  // R10
  busy_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == CSR_CTRL && busy) |=> ($stable(dir) && $stable(dev_id)));

endmodule

// File: rtl/dma_pager.sv
module dma_pager
  import dma_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned LEN_W      = 16,
  parameter int unsigned ID_W       = 4,
  parameter int unsigned PAGE_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ID_W-1:0]   dev_id,
  output logic              dev_req,
  input  logic              dev_ack,
  input  logic              dev_err,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  logic              start, cfg_dir, busy, fin, fault, dir, xfer_word;
  logic [ID_W-1:0]   cfg_id;
  logic [ADDR_W-1:0] cfg_addr, cur_addr;
  logic [LEN_W-1:0]  cfg_len, remain, chunk_len;

  // Reset is applied at once and removed on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  dma_csr #(
    .DATA_W (DATA_W), .ADDR_W (ADDR_W), .LEN_W (LEN_W), .ID_W (ID_W)
  ) u_csr (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .fin       (fin),
    .fault     (fault),
    .dir       (dir),
    .dev_id    (dev_id),
    .cur_addr  (cur_addr),
    .remain    (remain),
    .start     (start),
    .cfg_dir   (cfg_dir),
    .cfg_id    (cfg_id),
    .cfg_addr  (cfg_addr),
    .cfg_len   (cfg_len),
    .irq       (irq)
  );

  dma_chunk_calc #(
    .ADDR_W (ADDR_W), .LEN_W (LEN_W), .PAGE_WORDS (PAGE_WORDS)
  ) u_chunk (
    .addr   (cur_addr),
    .remain (remain),
    .chunk  (chunk_len)
  );

  dma_engine #(
    .ADDR_W (ADDR_W), .LEN_W (LEN_W), .ID_W (ID_W), .PAGE_WORDS (PAGE_WORDS)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (start),
    .cfg_dir   (cfg_dir),
    .cfg_id    (cfg_id),
    .cfg_addr  (cfg_addr),
    .cfg_len   (cfg_len),
    .chunk_len (chunk_len),
    .bus_gnt   (bus_gnt),
    .dev_ack   (dev_ack),
    .dev_err   (dev_err),
    .bus_req   (bus_req),
    .dev_req   (dev_req),
    .xfer_word (xfer_word),
    .dir       (dir),
    .dev_id    (dev_id),
    .cur_addr  (cur_addr),
    .remain    (remain),
    .busy      (busy),
    .fin       (fin),
    .fault     (fault)
  );

  assign mem_en    = xfer_word;
  assign mem_we    = !dir;
  assign mem_addr  = cur_addr;
  assign mem_wdata = dev_rdata;
  assign dev_wdata = mem_rdata;

  // R3
  grant_only_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    mem_en |-> (bus_gnt && bus_req));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_int |-> (!bus_req && !irq && !mem_en));

endmodule

// File: tb/test_dma_pager.sv
module test_dma_pager;

  localparam int PAGE = 16;

  typedef struct {
    logic [15:0] a;
    logic [31:0] d;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, bus_req, dev_req, mem_en, mem_we;
  logic        bus_gnt = 1'b0, dev_ack = 1'b0, dev_err = 1'b0;
  logic [3:0]  dev_id;
  logic [31:0] dev_rdata = '0, dev_wdata, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;

  logic [31:0] mem [256];
  item_t       exp_q[$];
  int          checks = 0, errors = 0;
  int          words = 0, chunks = 0, err_at = 0, cyc = 0;
  bit          err_armed = 0, req_seen = 0, req_prev = 0, gnt_prev = 0, tog = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[7:0]];

  dma_pager i_dma_pager (
    .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq (irq),
    .bus_req (bus_req), .bus_gnt (bus_gnt), .dev_id (dev_id),
    .dev_req (dev_req), .dev_ack (dev_ack), .dev_err (dev_err),
    .dev_rdata (dev_rdata), .dev_wdata (dev_wdata), .mem_en (mem_en),
    .mem_we (mem_we), .mem_addr (mem_addr), .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Arbiter, peripheral and scoreboard monitor.
  always begin
    @(negedge clk);
    bus_gnt   = bus_req && req_prev;
    req_prev  = bus_req;
    tog       = ~tog;
    dev_ack   = tog;
    dev_err   = err_armed && (words == err_at);
    dev_rdata = 32'hA500_0000 | words;
    #1;
    cyc++;
    if (bus_req) req_seen = 1;
    if (bus_gnt && !gnt_prev) chunks++;
    gnt_prev = bus_gnt;
    if (mem_en) begin
      if (!bus_gnt) chk("R3 word without grant", 32'(bus_gnt), 32'd1);
      if (exp_q.size() == 0) begin
        chk("R4/R5 unexpected word", 32'(mem_addr), 32'hFFFF_FFFF);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(mem_we ? "R4 address" : "R5 address", 32'(mem_addr), 32'(it.a));
        chk(mem_we ? "R4 data" : "R5 data", mem_we ? mem_wdata : dev_wdata, it.d);
      end
      if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
      words++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1.5;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4000; i++) begin
      reg_read(2'd3, s);
      if (!s[0]) break;
    end
  endtask

  function automatic int exp_chunks(input int a, input int n);
    int c = 0;
    while (n > 0) begin
      int room, k;
      room = PAGE - (a % PAGE);
      k = (n < room) ? n : room;
      c++; a += k; n -= k;
    end
    return c;
  endfunction

  task automatic arm(input bit dir, input int a, input int n, input int ea);
    words = 0; chunks = 0; req_seen = 0;
    err_at = ea; err_armed = (ea >= 0);
    for (int i = 0; i < ((ea >= 0) ? ea : n); i++) begin
      item_t it;
      it.a = 16'(a + i);
      it.d = dir ? mem[(a + i) % 256] : (32'hA500_0000 | i);
      exp_q.push_back(it);
    end
  endtask

  task automatic run(input bit dir, input int id, input int a, input int n, input int ea);
    arm(dir, a, n, ea);
    reg_write(2'd1, 32'(a));
    reg_write(2'd2, 32'(n));
    reg_write(2'd0, (32'(id) << 8) | (32'(dir) << 1) | 32'd1);
    wait_idle();
    err_armed = 0;
  endtask

  task automatic check_done(input string tag, input int a, input int n);
    reg_read(2'd3, rd); chk({tag, " R8 status done"}, rd, 32'd2);
    chk({tag, " R8 irq"}, 32'(irq), 32'd1);
    reg_read(2'd2, rd); chk({tag, " R8 remain"}, rd, 32'd0);
    reg_read(2'd1, rd); chk({tag, " R8 end address"}, rd, 32'(a + n));
    chk({tag, " R4 word count"}, 32'(words), 32'(n));
    chk({tag, " scoreboard empty"}, 32'(exp_q.size()), 32'd0);
    chk({tag, " R6 R7 chunks"}, 32'(chunks), 32'(exp_chunks(a, n)));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 | i;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1
    reg_read(2'd3, rd); chk("R1 status after reset", rd, 32'd0);
    chk("R1 irq after reset", 32'(irq), 32'd0);
    chk("R1 bus_req after reset", 32'(bus_req), 32'd0);

    // R4 with R6/R7: 4 + 16 words, two pages
    run(1'b0, 5, 'h1C, 20, -1);
    check_done("d2m", 'h1C, 20);

    // R5: three chunks 11 + 16 + 10
    run(1'b1, 9, 'h35, 37, -1);
    check_done("m2d", 'h35, 37);
    // R2 control readback
    reg_read(2'd0, rd); chk("R2 control readback", rd, 32'h0000_0902);

    // R9 clear by write
    reg_write(2'd3, 32'd6);
    reg_read(2'd3, rd); chk("R9 status cleared", rd, 32'd0);
    chk("R9 irq cleared", 32'(irq), 32'd0);

    // R11 zero length
    run(1'b0, 1, 'h80, 0, -1);
    reg_read(2'd3, rd); chk("R11 done on zero length", rd, 32'd2);
    chk("R11 no bus request", 32'(req_seen), 32'd0);
    chk("R11 irq", 32'(irq), 32'd1);

    // R12 error after three words
    run(1'b0, 2, 'h40, 10, 3);
    reg_read(2'd3, rd); chk("R12 status error only", rd, 32'd4);
    reg_read(2'd2, rd); chk("R12 remaining count", rd, 32'd7);
    reg_read(2'd1, rd); chk("R12 stop address", rd, 32'h43);
    chk("R12 words moved", 32'(words), 32'd3);
    chk("R12 scoreboard empty", 32'(exp_q.size()), 32'd0);
    chk("R12 irq", 32'(irq), 32'd1);
    repeat (10) @(negedge clk);
    reg_read(2'd3, rd); chk("R9 error sticky", rd, 32'd4);

    // R9: new go clears error; aligned full page is one chunk (R6)
    run(1'b0, 3, 'h90, 16, -1);
    check_done("aligned", 'h90, 16);

    // R7: two words across a boundary give two grants
    reg_write(2'd3, 32'd6);
    run(1'b1, 4, 'hAF, 2, -1);
    check_done("straddle", 'hAF, 2);

    // R10: go while busy is ignored
    arm(1'b0, 'h60, 12, -1);
    reg_write(2'd1, 32'h60);
    reg_write(2'd2, 32'd12);
    reg_write(2'd0, 32'h0000_0601);
    repeat (4) @(negedge clk);
    reg_write(2'd0, 32'h0000_0F03);
    reg_write(2'd1, 32'h10);
    wait_idle();
    check_done("R10 busy go", 'h60, 12);
    reg_read(2'd0, rd); chk("R10 control unchanged", rd, 32'h0000_0600);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule